// File: doc/BRIEF.md
# Area Decoder with Wait Control

This block sits between a bus master and the memory devices of a 16 MB byte-addressed space. It splits the space into eight equal 2 MB areas by the three most significant of the 24 address bits. Area 0 is served by a DRAM controller, so its select becomes a row-strobe request. Areas 1 to 7 each drive a plain chip select. Every area has its own wait-state count and its own bus-cycle type code, both held in a small configuration store.

When the master pulses the cycle-start strobe, the block latches the decoded area with that area's wait count and type. It then drives the area's select low and keeps it there for the programmed number of wait clocks. Ready goes high in the final clock of the access. Configuration writes go through a one-beat register port and only affect accesses that start after the write.

Top module: `area_wait_decoder`

## Requirements
- R1: During and after synchronous reset (rst_n low at a clock edge), row_req_n and every cs_n bit are high, ready is low and cyc_type is 0.
- R2: An accepted start latches area = addr[23:21]. Area 0 drives row_req_n low and area k (1 to 7) drives cs_n[k-1] low. addr[20:0] has no effect on which select is driven.
- R3: At most one of the eight selects is low at any time, and all of them are high while no access is in progress.
- R4: If a start with wait count w is accepted at clock edge E, the area's select is low for the w+1 cycles after E. Ready is high only in the last of those cycles. The select returns high after that cycle unless a new start is accepted at the same edge.
- R5: Each area's wait count is a 3-bit value from 0 to 7, set independently of the other areas, and it sets the number of cycles before ready.
- R6: While an access is active, cyc_type shows the 2-bit type code that was stored for the access's area when the access started. cyc_type is 0 when idle.
- R7: A cyc_start that arrives while an access is active and ready is low is ignored. The select, the wait timing and cyc_type of the running access are unchanged.
- R8: A cyc_start in the cycle where ready is high is accepted, and the next access's select is driven in the following cycle with no idle gap.
- R9: With cfg_we high at a clock edge, cfg_wait and cfg_type are stored for area cfg_area. A stored change never alters an access already in progress. A start accepted at the same edge as the write uses the value that was stored before that edge.
- R10: After reset every area has wait count 7 and type code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | Byte address of the access to start |
| cyc_start | input | 1 | Start an access at this clock edge |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | 3 | Area whose configuration is written |
| cfg_wait | input | 3 | Wait count to store |
| cfg_type | input | 2 | Cycle type code to store |
| row_req_n | output | 1 | Active-low DRAM row-strobe request (area 0) |
| cs_n | output | 7 | Active-low chip selects; bit k-1 serves area k |
| cyc_type | output | 2 | Cycle type code of the active access |
| ready | output | 1 | High in the final cycle of an access |

## Verification
Two cases are the hardest to reach from the ports. The first is a configuration write aimed at the area of an access that is still in flight. The second is a write that lands on the same edge as a start to that area. To reach them, the stimulus starts a long access to area 7 and rewrites area 7's wait count two cycles later. It also raises cfg_we and cyc_start together for area 4. The reference model keeps the old count in both cases, so any early pickup of the new value shows up as a ready-timing mismatch. Back-to-back acceptance is exercised by holding cyc_start high for many cycles while the address changes on every cycle.

// File: rtl/awd_pkg.sv
// Package awd_pkg: shared definitions for the area decoder with wait control.
// Assumes the address space is split into a power-of-two number of equal areas.
package awd_pkg;
    // Default geometry of the decoded space
    localparam int unsigned AWD_ADDR_W    = 24;
    localparam int unsigned AWD_AREA_BITS = 3;
    localparam int unsigned AWD_WAIT_W    = 3;
    localparam int unsigned AWD_TYPE_W    = 2;
    // Area served by the DRAM row-strobe request
    localparam int unsigned AWD_DRAM_AREA = 0;
endpackage

// File: rtl/awd_area_decode.sv
// Module awd_area_decode: turns the top address bits into an area index.
// Assumes equal-sized areas selected by the most significant address bits.
module awd_area_decode #(
    parameter int unsigned ADDR_W    = awd_pkg::AWD_ADDR_W,
    parameter int unsigned AREA_BITS = awd_pkg::AWD_AREA_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [AREA_BITS-1:0] area
);
    localparam int unsigned LOW_W = ADDR_W - AREA_BITS;

    logic unused_low_bits;

    // Area index comes from the top address bits only
    assign area            = addr[ADDR_W-1 -: AREA_BITS];
    assign unused_low_bits = ^addr[LOW_W-1:0];
endmodule

// File: rtl/awd_cfg_regs.sv
// Module awd_cfg_regs: per-area wait count and cycle type storage.
// A write lands at the clock edge. The read port is combinational, so a start
// at the same edge sees the value stored before the write.
module awd_cfg_regs #(
    parameter int unsigned AREA_BITS = awd_pkg::AWD_AREA_BITS,
    parameter int unsigned WAIT_W    = awd_pkg::AWD_WAIT_W,
    parameter int unsigned TYPE_W    = awd_pkg::AWD_TYPE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AREA_BITS-1:0] wr_area,
    input  logic [WAIT_W-1:0]    wr_wait,
    input  logic [TYPE_W-1:0]    wr_type,
    input  logic [AREA_BITS-1:0] rd_area,
    output logic [WAIT_W-1:0]    rd_wait,
    output logic [TYPE_W-1:0]    rd_type
);
    localparam int unsigned NUM_AREAS = 1 << AREA_BITS;

    logic [WAIT_W-1:0] wait_q [NUM_AREAS];
    logic [TYPE_W-1:0] type_q [NUM_AREAS];

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        // Hold one area's settings; reset to the slowest wait and type 0
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_q[i] <= '1;
                type_q[i] <= '0;
            end else if (wr_en && (wr_area == AREA_BITS'(i))) begin
                wait_q[i] <= wr_wait;
                type_q[i] <= wr_type;
            end
        end
    end

    // Read out the settings of the addressed area
    assign rd_wait = wait_q[rd_area];
    assign rd_type = type_q[rd_area];
endmodule

// File: rtl/awd_wait_seq.sv
// Module awd_wait_seq: runs one access at a time and counts its wait clocks.
// A start is taken when idle or in the ready cycle. Starts at any other time
// are dropped.
module awd_wait_seq #(
    parameter int unsigned AREA_BITS = awd_pkg::AWD_AREA_BITS,
    parameter int unsigned WAIT_W    = awd_pkg::AWD_WAIT_W,
    parameter int unsigned TYPE_W    = awd_pkg::AWD_TYPE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AREA_BITS-1:0] area_in,
    input  logic [WAIT_W-1:0]    wait_in,
    input  logic [TYPE_W-1:0]    type_in,
    output logic                 active,
    output logic [AREA_BITS-1:0] area_out,
    output logic [TYPE_W-1:0]    type_out,
    output logic                 ready
);
    logic                 active_q;
    logic [AREA_BITS-1:0] area_q;
    logic [TYPE_W-1:0]    type_q;
    logic [WAIT_W-1:0]    cnt_q;
    logic                 last_cycle;
    logic                 accept;

    // Final cycle of an access, and whether a start is taken now
    assign last_cycle = active_q && (cnt_q == '0);
    assign accept     = start && (!active_q || last_cycle);

    // Access state: capture on accept, count down, then go idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            area_q   <= '0;
            type_q   <= '0;
            cnt_q    <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            area_q   <= area_in;
            type_q   <= type_in;
            cnt_q    <= wait_in;
        end else if (last_cycle) begin
            active_q <= 1'b0;
            type_q   <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q - WAIT_W'(1);
        end
    end

    // Expose the access state
    assign active   = active_q;
    assign area_out = area_q;
    assign type_out = type_q;
    assign ready    = last_cycle;
endmodule

// File: rtl/area_wait_decoder.sv
// Module area_wait_decoder: eight-area decoder with per-area wait control.
// Area DRAM_AREA (0) drives the row-strobe request and the other areas drive
// active-low chip selects. Assumes a single master issuing one access at a time.
module area_wait_decoder #(
    parameter int unsigned ADDR_W    = awd_pkg::AWD_ADDR_W,
    parameter int unsigned AREA_BITS = awd_pkg::AWD_AREA_BITS,
    parameter int unsigned WAIT_W    = awd_pkg::AWD_WAIT_W,
    parameter int unsigned TYPE_W    = awd_pkg::AWD_TYPE_W,
    localparam int unsigned NUM_AREAS = 1 << AREA_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 cyc_start,
    input  logic                 cfg_we,
    input  logic [AREA_BITS-1:0] cfg_area,
    input  logic [WAIT_W-1:0]    cfg_wait,
    input  logic [TYPE_W-1:0]    cfg_type,
    output logic                 row_req_n,
    output logic [NUM_AREAS-2:0] cs_n,
    output logic [TYPE_W-1:0]    cyc_type,
    output logic                 ready
);
    logic [AREA_BITS-1:0] dec_area;
    logic [WAIT_W-1:0]    sel_wait;
    logic [TYPE_W-1:0]    sel_type;
    logic                 seq_active;
    logic [AREA_BITS-1:0] seq_area;
    logic [NUM_AREAS-1:0] area_hit;

    awd_area_decode #(
        .ADDR_W    (ADDR_W),
        .AREA_BITS (AREA_BITS)
    ) u_decode (
        .addr (addr),
        .area (dec_area)
    );

    awd_cfg_regs #(
        .AREA_BITS (AREA_BITS),
        .WAIT_W    (WAIT_W),
        .TYPE_W    (TYPE_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_area (cfg_area),
        .wr_wait (cfg_wait),
        .wr_type (cfg_type),
        .rd_area (dec_area),
        .rd_wait (sel_wait),
        .rd_type (sel_type)
    );

    awd_wait_seq #(
        .AREA_BITS (AREA_BITS),
        .WAIT_W    (WAIT_W),
        .TYPE_W    (TYPE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .area_in  (dec_area),
        .wait_in  (sel_wait),
        .type_in  (sel_type),
        .active   (seq_active),
        .area_out (seq_area),
        .type_out (cyc_type),
        .ready    (ready)
    );

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_hit
        // One hit line per area, high only while that area's access runs
        assign area_hit[i] = seq_active && (seq_area == AREA_BITS'(i));
    end

    // Route the DRAM area to the row request and the rest to chip selects
    assign row_req_n = ~area_hit[awd_pkg::AWD_DRAM_AREA];
    assign cs_n      = ~area_hit[NUM_AREAS-1:1];
endmodule

// File: rtl/awd_chk.sv
// Module awd_chk: temporal checks on the area decoder's ports.
// Bound to area_wait_decoder below. Sees only the block's ports.
module awd_chk #(
    parameter int unsigned AREA_BITS = awd_pkg::AWD_AREA_BITS,
    parameter int unsigned TYPE_W    = awd_pkg::AWD_TYPE_W,
    localparam int unsigned NUM_AREAS = 1 << AREA_BITS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AREA_BITS-1:0] area_bits,
    input logic                 cyc_start,
    input logic                 row_req_n,
    input logic [NUM_AREAS-2:0] cs_n,
    input logic [TYPE_W-1:0]    cyc_type,
    input logic                 ready
);
    logic [NUM_AREAS-1:0] sel_act;
    logic [AREA_BITS-1:0] prev_area;
    logic                 idle;

    assign sel_act = ~{cs_n, row_req_n};
    assign idle    = (sel_act == '0);

    // Remember last cycle's address area for the start check
    always_ff @(posedge clk) begin
        if (!rst_n) prev_area <= '0;
        else        prev_area <= area_bits;
    end

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_act));

    // R2
    start_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cyc_start) |=> (sel_act == (NUM_AREAS'(1) << prev_area)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !ready) |=> ($stable(sel_act) && $stable(cyc_type)));

    // R4
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cyc_start) |=> idle);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!ready && (cyc_type == '0)));

    // R8
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cyc_start) |=> ($countones(sel_act) == 1));
endmodule

bind area_wait_decoder awd_chk #(
    .AREA_BITS (AREA_BITS),
    .TYPE_W    (TYPE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .area_bits (addr[ADDR_W-1 -: AREA_BITS]),
    .cyc_start (cyc_start),
    .row_req_n (row_req_n),
    .cs_n      (cs_n),
    .cyc_type  (cyc_type),
    .ready     (ready)
);

// File: tb/area_wait_decoder_tb.sv
`timescale 1ns/1ps
module area_wait_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] addr;
    logic        cyc_start;
    logic        cfg_we;
    logic [2:0]  cfg_area;
    logic [2:0]  cfg_wait;
    logic [1:0]  cfg_type;
    logic        row_req_n;
    logic [6:0]  cs_n;
    logic [1:0]  cyc_type;
    logic        ready;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";

    // Behavioural reference state
    int m_busy, m_cnt, m_area, m_type;
    int m_wait_tab[8];
    int m_type_tab[8];

    area_wait_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .cyc_start (cyc_start),
        .cfg_we    (cfg_we),
        .cfg_area  (cfg_area),
        .cfg_wait  (cfg_wait),
        .cfg_type  (cfg_type),
        .row_req_n (row_req_n),
        .cs_n      (cs_n),
        .cyc_type  (cyc_type),
        .ready     (ready)
    );

    always #4 clk = ~clk;

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_area = 0; m_type = 0;
            for (int i = 0; i < 8; i++) begin
                m_wait_tab[i] = 7;
                m_type_tab[i] = 0;
            end
        end else begin
            int take;
            take = (cyc_start && (!m_busy || m_cnt == 0)) ? 1 : 0;
            if (take) begin
                m_busy = 1;
                m_area = int'(addr[23:21]);
                m_cnt  = m_wait_tab[m_area];
                m_type = m_type_tab[m_area];
            end else if (m_busy && m_cnt == 0) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_cnt = m_cnt - 1;
            end
            if (cfg_we) begin
                m_wait_tab[cfg_area] = int'(cfg_wait);
                m_type_tab[cfg_area] = int'(cfg_type);
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model between edges
    always @(negedge clk) begin
        logic [7:0] exp_sel;
        exp_sel = 8'hFF;
        if (m_busy) exp_sel[m_area] = 1'b0;
        check("selects", int'({cs_n, row_req_n}), int'(exp_sel));
        check("ready", int'(ready), (m_busy && m_cnt == 0) ? 1 : 0);
        check("cyc_type", int'(cyc_type), m_busy ? m_type : 0);
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_at(int area, logic [20:0] low);
        addr      = {area[2:0], low};
        cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
    endtask

    task automatic write_cfg(int area, int w, int t);
        cfg_we   = 1'b1;
        cfg_area = area[2:0];
        cfg_wait = w[2:0];
        cfg_type = t[1:0];
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; addr = '0; cyc_start = 1'b0;
        cfg_we = 1'b0; cfg_area = '0; cfg_wait = '0; cfg_type = '0;
        // R1: reset state, including a start held during reset
        cur_req = "R1";
        step(2);
        cyc_start = 1'b1;
        step(2);
        cyc_start = 1'b0;
        rst_n = 1'b1;
        step(2);

        // R10: default wait 7 and type 0 in every area
        cur_req = "R10";
        for (int a = 0; a < 8; a++) begin
            start_at(a, 21'(a * 12345));
            step(9);
        end

        // R5: program distinct waits and types per area
        cur_req = "R5";
        for (int a = 0; a < 8; a++) write_cfg(a, 7 - a, a % 4);
        for (int a = 0; a < 8; a++) begin
            start_at(a, 21'h1FFFFF);
            step(9);
        end

        // R2: low address bits do not change the area
        cur_req = "R2";
        for (int a = 0; a < 8; a++) begin
            start_at(a, 21'h000000);
            step(9);
            start_at(a, 21'h155555);
            step(9);
        end

        // R6: type codes follow the area
        cur_req = "R6";
        for (int a = 0; a < 8; a++) write_cfg(a, a % 3, 3 - (a % 4));
        for (int a = 7; a >= 0; a--) begin
            start_at(a, 21'h0ABCDE);
            step(4);
        end

        // R4: zero wait and full wait lengths
        cur_req = "R4";
        write_cfg(1, 0, 1);
        write_cfg(2, 7, 2);
        start_at(1, 21'h0);
        step(3);
        start_at(2, 21'h0);
        step(10);

        // R7: starts during an active access are ignored
        cur_req = "R7";
        start_at(2, 21'h0);
        start_at(5, 21'h0);
        start_at(6, 21'h0);
        step(2);
        start_at(3, 21'h0);
        step(8);

        // R8: start held high chains accesses back to back
        cur_req = "R8";
        cyc_start = 1'b1;
        for (int i = 0; i < 40; i++) begin
            addr = 24'($urandom);
            step();
        end
        cyc_start = 1'b0;
        step(10);

        // R9: rewrite an in-flight area and write on the start edge
        cur_req = "R9";
        write_cfg(7, 7, 3);
        start_at(7, 21'h0);
        step();
        write_cfg(7, 1, 1);
        step(8);
        start_at(7, 21'h0);
        step(4);
        write_cfg(4, 4, 2);
        addr      = {3'd4, 21'h0};
        cyc_start = 1'b1;
        cfg_we    = 1'b1; cfg_area = 3'd4; cfg_wait = 3'd0; cfg_type = 2'd1;
        step();
        cyc_start = 1'b0;
        cfg_we    = 1'b0;
        step(7);
        start_at(4, 21'h0);
        step(3);

        // R3: random mix of starts and writes
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            addr      = 24'($urandom);
            cyc_start = ($urandom % 3) == 0;
            cfg_we    = ($urandom % 7) == 0;
            cfg_area  = 3'($urandom);
            cfg_wait  = 3'($urandom);
            cfg_type  = 2'($urandom);
            step();
        end
        cyc_start = 1'b0;
        cfg_we    = 1'b0;
        step(10);

        // R1: reset in the middle of an access
        cur_req = "R1";
        start_at(2, 21'h0);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        finish_run();
    end
endmodule